// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a register of parameterised width (eight bits by default) that can keep its value, shift toward its top bit, shift toward its bottom bit, or take a whole word in parallel. A two-bit mode select picks one of these four operations on each rising clock edge. An active-low clear acts at once, without a clock, and empties the register whatever the other inputs are doing.

One shared word-wide port carries parallel data in both directions. The port drive is split into a data-in bus, a data-out bus and a single enable. The enable is high only while both active-low output enables are low and the mode is not parallel load. While parallel load is selected, the port is released so that outside logic can drive it. The load then takes place on the next edge whatever the output enables are.

Each end of the register has a serial input and a serial tap. Several registers can be chained in either direction by connecting the tap at one end of a stage to the serial input at the facing end of its neighbour. Feeding the far tap back to the first stage makes the whole chain rotate.

Top module: `ushift_reg`

## Requirements
- R1: With select {sel[1],sel[0]} = 00 the register keeps its value across clock edges, whatever the serial inputs carry.
- R2: With select 01, each rising edge moves every bit one place toward the top bit, and serInLo enters bit 0.
- R3: With select 10, each rising edge moves every bit one place toward bit 0, and serInHi enters the top bit.
- R4: With select 11, io_oe is low and io_in is copied into every bit on the next rising edge, for any value of outEnN.
- R5: io_oe is high, and io_out presents the register contents, exactly when every bit of outEnN is low and the select is not 11.
- R6: If any bit of outEnN is high, io_oe is low.
- R7: A low rstN clears every bit at once, without waiting for a clock edge, and the register stays clear on clock edges while rstN is low, whatever the mode.
- R8: serOutLo always equals register bit 0 and serOutHi always equals the top register bit. Neither tap depends on the output enables.
- R9: Two stages chained top-tap to bottom-input, and bottom-tap to top-input, shift as one register of twice the width in both directions.
- R10: Feeding the last stage's top tap to the first stage's bottom input (and the first stage's bottom tap to the last stage's top input) rotates the chained contents without losing any bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous clear, active low |
| sel | input | 2 | Mode: 00 hold, 01 shift toward top, 10 shift toward bit 0, 11 parallel load |
| outEnN | input | N_OE | Output enables, active low; any high bit turns the port drive off |
| serInLo | input | 1 | Serial data entering bit 0 when shifting toward the top |
| serInHi | input | 1 | Serial data entering the top bit when shifting toward bit 0 |
| io_in | input | WIDTH | Value seen on the shared port, loaded in mode 11 |
| io_out | output | WIDTH | Register contents presented to the shared port |
| io_oe | output | 1 | High when the shared port should be driven with io_out |
| serOutLo | output | 1 | Tap of register bit 0 |
| serOutHi | output | 1 | Tap of the top register bit |

## Verification
The bench builds the block with its defaults, WIDTH = 8 and N_OE = 2. It places two instances in a chain, so that shifts carry bits across the stage boundary and the chain can rotate a sixteen-bit word. The first stage's port is a real tri-state net driven by both the block and the bench. This lets the bench reach every one of the sixteen combinations of enable pair and mode, and also check that a load arrives through a port the block has released.

// File: rtl/ushift_pkg.sv
package ushift_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  // one-hot (or all-zero for hold) strobes from control to datapath
  typedef struct packed {
    logic shiftUp;
    logic shiftDown;
    logic load;
  } strobe_t;

endpackage

// File: rtl/ushift_ctrl.sv
module ushift_ctrl
  import ushift_pkg::*;
#(
  parameter int N_OE = 2
) (
  input  logic [1:0]      sel,
  input  logic [N_OE-1:0] outEnN,
  output strobe_t         strobe,
  output logic            portDrive
);

  mode_e mode;
  logic  allEnabled;

  assign mode = mode_e'(sel);

  always_comb begin
    strobe = '0;
    unique case (mode)
      MODE_HOLD: strobe = '0;
      MODE_UP:   strobe.shiftUp = 1'b1;
      MODE_DOWN: strobe.shiftDown = 1'b1;
      MODE_LOAD: strobe.load = 1'b1;
      default:   strobe = '0;
    endcase
  end

  // every active-low enable must be asserted for the port to drive
  assign allEnabled = (outEnN == '0);
  assign portDrive  = allEnabled && (mode != MODE_LOAD);

endmodule

// File: rtl/ushift_dpath.sv
module ushift_dpath
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             serInLo,
  input  logic             serInHi,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] stateQ
);

  localparam int EXT_W = WIDTH + 2;

  logic [WIDTH-1:0] stateD;
  logic [EXT_W-1:0] extState;

  // the serial inputs sit just beyond each end so every bit sees a uniform neighbourhood
  assign extState = {serInHi, stateQ, serInLo};

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      if (strobe.load)           stateD[i] = parIn[i];
      else if (strobe.shiftUp)   stateD[i] = extState[i];
      else if (strobe.shiftDown) stateD[i] = extState[i+2];
      else                       stateD[i] = stateQ[i];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '0;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
  import ushift_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int N_OE  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       sel,
  input  logic [N_OE-1:0]  outEnN,
  input  logic             serInLo,
  input  logic             serInHi,
  input  logic [WIDTH-1:0] io_in,
  output logic [WIDTH-1:0] io_out,
  output logic             io_oe,
  output logic             serOutLo,
  output logic             serOutHi
);

  strobe_t          strobe;
  logic [WIDTH-1:0] stateQ;

  ushift_ctrl #(.N_OE(N_OE)) u_ctrl (
    .sel       (sel),
    .outEnN    (outEnN),
    .strobe    (strobe),
    .portDrive (io_oe)
  );

  ushift_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .serInLo (serInLo),
    .serInHi (serInHi),
    .parIn   (io_in),
    .stateQ  (stateQ)
  );

  assign io_out   = stateQ;
  assign serOutLo = stateQ[0];
  assign serOutHi = stateQ[WIDTH-1];

endmodule

// File: rtl/ushift_reg_chk.sv
module ushift_reg_chk #(
  parameter int WIDTH = 8,
  parameter int N_OE  = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       sel,
  input logic [N_OE-1:0]  outEnN,
  input logic             serInLo,
  input logic             serInHi,
  input logic [WIDTH-1:0] io_in,
  input logic [WIDTH-1:0] io_out,
  input logic             io_oe,
  input logic             serOutLo,
  input logic             serOutHi
);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 2'b00) |=> $stable(io_out));

  p_shift_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 2'b01) |=> (io_out == {$past(io_out[WIDTH-2:0]), $past(serInLo)}));

  p_shift_down_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 2'b10) |=> (io_out == {$past(serInHi), $past(io_out[WIDTH-1:1])}));

  p_load_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 2'b11) |=> (io_out == $past(io_in)));

  p_released_r4: assert property (@(posedge clk) disable iff (!rstN)
    (sel == 2'b11) |-> !io_oe);

  p_drive_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((outEnN == '0) && (sel != 2'b11)) |-> io_oe);

  p_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    (outEnN != '0) |-> !io_oe);

  p_taps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (serOutLo == io_out[0]) && (serOutHi == io_out[WIDTH-1]));

endmodule

bind ushift_reg ushift_reg_chk #(.WIDTH(WIDTH), .N_OE(N_OE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .sel      (sel),
  .outEnN   (outEnN),
  .serInLo  (serInLo),
  .serInHi  (serInHi),
  .io_in    (io_in),
  .io_out   (io_out),
  .io_oe    (io_oe),
  .serOutLo (serOutLo),
  .serOutHi (serOutHi)
);

// File: tb/ushift_pad.sv
module ushift_pad #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] dout,
  input  logic             oe,
  inout  wire  [WIDTH-1:0] pad,
  output logic [WIDTH-1:0] din
);
  assign pad = oe ? dout : 'z;
  assign din = pad;
endmodule

// File: tb/ushift_reg_test.sv
module ushift_reg_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] sel = 2'b00;
  logic [1:0] outEnN = 2'b11;
  logic tbSerLo = 1'b0, tbSerHi = 1'b0, recirc = 1'b0;
  logic [W-1:0] hiLoadVal = '0;
  logic tbBusDrive = 1'b0;
  logic [W-1:0] tbBusVal = '0;

  wire  [W-1:0] padBus;
  logic [W-1:0] loIoOut, loIoIn, hiIoOut;
  logic loIoOe, hiIoOe, loQ0, loQ7, hiQ0, hiQ7;
  logic loSerIn, hiSerIn;

  assign loSerIn = recirc ? hiQ7 : tbSerLo;
  assign hiSerIn = recirc ? loQ0 : tbSerHi;
  assign padBus  = tbBusDrive ? tbBusVal : 'z;

  ushift_pad #(.WIDTH(W)) u_pad (.dout(loIoOut), .oe(loIoOe), .pad(padBus), .din(loIoIn));

  ushift_reg #(.WIDTH(W), .N_OE(2)) uut (
    .clk(clk), .rstN(rstN), .sel(sel), .outEnN(outEnN),
    .serInLo(loSerIn), .serInHi(hiQ0), .io_in(loIoIn),
    .io_out(loIoOut), .io_oe(loIoOe), .serOutLo(loQ0), .serOutHi(loQ7));

  ushift_reg #(.WIDTH(W), .N_OE(2)) uutHi (
    .clk(clk), .rstN(rstN), .sel(sel), .outEnN(outEnN),
    .serInLo(loQ7), .serInHi(hiSerIn), .io_in(hiLoadVal),
    .io_out(hiIoOut), .io_oe(hiIoOe), .serOutLo(hiQ0), .serOutHi(hiQ7));

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  bit model[$];
  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] packModel();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) v[i] = model[i];
    return v;
  endfunction

  // advance model and design one clock, then compare at the falling edge
  task automatic step();
    bit inLo, inHi;
    string tag;
    inLo = recirc ? model[15] : tbSerLo;
    inHi = recirc ? model[0] : tbSerHi;
    case (sel)
      2'b01: begin model.push_front(inLo); void'(model.pop_back()); end
      2'b10: begin model.push_back(inHi); void'(model.pop_front()); end
      2'b11: for (int i = 0; i < 8; i++) begin
               model[i] = tbBusVal[i];
               model[8+i] = hiLoadVal[i];
             end
      default: ;
    endcase
    case (sel)
      2'b00: tag = "R1 hold";
      2'b01: tag = recirc ? "R10 rotate up" : "R2 R9 shift up";
      2'b10: tag = recirc ? "R10 rotate down" : "R3 R9 shift down";
      default: tag = "R4 load";
    endcase
    @(posedge clk);
    @(negedge clk);
    chk(tag, {hiIoOut, loIoOut}, packModel());
    chk("R8 taps", {12'h0, hiQ7, hiQ0, loQ7, loQ0},
        {12'h0, model[15], model[8], model[7], model[0]});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=running expected=finished");
    summary();
    $finish;
  end

  localparam logic [15:0] PATTERN = 16'hB38E;

  initial begin
    for (int i = 0; i < 16; i++) model.push_back(1'b0);
    #1;
    chk("R7 reset contents", {hiIoOut, loIoOut}, 16'h0);
    chk("R6 enables high", {15'h0, loIoOe}, 16'h0);
    @(negedge clk);
    rstN = 1'b1;

    // parallel load through the released shared port
    sel = 2'b11; outEnN = 2'b00; tbBusDrive = 1'b1; tbBusVal = 8'hA5; hiLoadVal = 8'h3C;
    #1 chk("R4 port released in load", {15'h0, loIoOe}, 16'h0);
    step();
    // load with enables off
    outEnN = 2'b10; tbBusVal = 8'h5A; hiLoadVal = 8'hC3;
    step();

    // hold while serial inputs toggle
    sel = 2'b00; tbBusDrive = 1'b0; outEnN = 2'b00;
    for (int i = 0; i < 3; i++) begin
      tbSerLo = ~tbSerLo; tbSerHi = ~tbSerHi;
      step();
    end
    chk("R5 driving in hold", {15'h0, loIoOe}, 16'h1);
    chk("R5 pad value", {8'h0, padBus}, {8'h0, loIoOut});

    // cascaded shifts both ways
    sel = 2'b01;
    for (int i = 0; i < 20; i++) begin tbSerLo = PATTERN[i % 16]; step(); end
    sel = 2'b10;
    for (int i = 0; i < 20; i++) begin tbSerHi = PATTERN[(i + 5) % 16]; step(); end

    // recirculation
    sel = 2'b11; tbBusDrive = 1'b1; tbBusVal = 8'h81; hiLoadVal = 8'h17;
    step();
    tbBusDrive = 1'b0; recirc = 1'b1; sel = 2'b01;
    for (int i = 0; i < 16; i++) step();
    chk("R10 full rotation restores", {hiIoOut, loIoOut}, 16'h1781);
    sel = 2'b10;
    for (int i = 0; i < 5; i++) step();
    recirc = 1'b0;

    // port direction in every enable/mode combination
    for (int oe = 0; oe < 4; oe++) begin
      for (int s = 0; s < 4; s++) begin
        outEnN = oe[1:0]; sel = s[1:0];
        tbBusDrive = (s == 3); tbBusVal = 8'(oe * 16 + s + 8'h40);
        hiLoadVal = 8'(8'h90 + oe);
        #1;
        chk((oe != 0) ? "R6 direction" : "R5 direction", {15'h0, loIoOe},
            {15'h0, (oe == 0 && s != 3)});
        if (oe == 0 && s != 3) chk("R5 pad value", {8'h0, padBus}, {8'h0, loIoOut});
        step();
      end
    end

    // asynchronous clear, overriding a load
    sel = 2'b11; tbBusDrive = 1'b1; tbBusVal = 8'hFF; hiLoadVal = 8'hFF;
    step();
    #2 rstN = 1'b0;
    #1;
    chk("R7 async clear", {hiIoOut, loIoOut}, 16'h0);
    chk("R7 taps cleared", {12'h0, hiQ7, hiQ0, loQ7, loQ0}, 16'h0);
    @(posedge clk);
    @(negedge clk);
    chk("R7 clear overrides load", {hiIoOut, loIoOut}, 16'h0);
    for (int i = 0; i < 16; i++) model[i] = 1'b0;
    rstN = 1'b1; sel = 2'b00; tbBusDrive = 1'b0;
    step();

    summary();
    $finish;
  end

endmodule